// File: doc/BRIEF.md
# Frequency Level Controller with Voltage Ramp Hold-Off

This block keeps the operating frequency level of a processor core. Levels are numbered from 0, the fastest, upward; a parameter mask says which levels may be used, and disabled levels are skipped. Load-tracking logic outside the block presents a two-bit request: hold, slower (load fell), faster (load rose) or panic (jump to full speed). When automatic mode is off, software can pick a level through a separate manual port.

For each level change the block decides whether the core is scaling up or down, and how many voltage steps the regulator should take. It also decides whether the target level needs the other PLL, which means a PLL reprogram, or only new post-divider values. Then it holds off all further requests for a voltage ramp wait. That wait is a fixed time, turned into clock cycles through a clock-frequency parameter. When the wait ends, the block emits a one-cycle divider write strobe, and a PLL write strobe as well when a PLL change was chosen. The write values come from per-level parameter tables. Four counters record accepted slower, faster, panic and hold events.

The request and manual-set inputs are plain control pins sampled on a valid flag, with no back-pressure. A request that arrives while the block cannot take it is dropped, not stalled. `ramp_busy` shows when requests are being dropped because of the ramp wait.

Top module: `dvfs_lvl_ctrl`

## Requirements
- R1: After reset the level equals DEFAULT_LEVEL, `pll_sel` equals that level's bit in PLL_SEL_TABLE, `ramp_busy`, `div_wr` and `pll_wr` are low, and all four event counters are zero.
- R2: A request with code 1 (slower) moves the level to the smallest index above the current one whose LEVEL_MASK bit is set. It is ignored when no such index exists, which includes being at the last index.
- R3: A request with code 2 (faster) moves the level to the largest index below the current one whose LEVEL_MASK bit is set. It is ignored at index 0.
- R4: A request with code 3 (panic) moves the level straight to index 0. It is ignored when the level is already 0.
- R5: A request on `req_valid` is ignored, and the level does not change, while `ramp_busy` is high, while `upd_rdy` is low, or while `auto_en` is low.
- R6: On a change to a lower index, `scale_up` becomes 1 and `vsteps` takes the target level's entry in VSTEP_TABLE. On a change to a higher index, `scale_up` becomes 0 and `vsteps` becomes 1. Both outputs are valid from the cycle after the accepting edge.
- R7: If the target level's PLL_SEL_TABLE bit differs from `pll_sel`, then `pll_sel` toggles and a PLL write follows the ramp. Otherwise `pll_sel` holds and only a divider write follows.
- R8: A change sets `ramp_busy` for exactly CLK_MHZ*RAMP_US cycles. In the cycle after it drops, `div_wr` pulses for one cycle with `div_val` equal to the new level's DIV_TABLE entry, and `pll_wr` pulses with it when R7 chose a PLL update, carrying that level's PLL_TABLE entry.
- R9: Each accepted request that moves the level adds one to `cnt_dn` (slower), `cnt_up` (faster) or `cnt_pnc` (panic). An accepted request with code 0 (hold) adds one to `cnt_none`. Ignored requests and manual sets change no counter.
- R10: A manual set on `man_valid` is taken only while `auto_en` is low, `upd_rdy` is high and `ramp_busy` is low, and only when `man_level` has its mask bit set and differs from the current level. An accepted manual set follows R6, R7 and R8 like any other change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Automatic request mode on |
| upd_rdy | input | 1 | Clock tree ready to accept an update |
| req_valid | input | 1 | Request code is present this cycle |
| req_code | input | 2 | 0 hold, 1 slower, 2 faster, 3 panic |
| man_valid | input | 1 | Manual level set present this cycle |
| man_level | input | LW | Manually requested level |
| level | output | LW | Current level index |
| scale_up | output | 1 | Last change went to a faster level |
| vsteps | output | VSW | Voltage step count of the last change |
| pll_sel | output | 1 | Selected PLL |
| ramp_busy | output | 1 | Voltage ramp wait running, requests dropped |
| div_wr | output | 1 | Post-divider write strobe |
| div_val | output | DIVW | Post-divider value for the current level |
| pll_wr | output | 1 | PLL write strobe |
| pll_val | output | PLLW | PLL setting for the current level |
| cnt_dn | output | CNT_W | Slower events |
| cnt_up | output | CNT_W | Faster events |
| cnt_pnc | output | CNT_W | Panic events |
| cnt_none | output | CNT_W | Hold events |

## Verification
The bench builds the block with six levels and mask 6'b110101, so levels 1 and 3 are disabled and both slower and faster moves must skip over them. The default level is 2. Levels 4 and 5 sit on the second PLL, so PLL-swap and divider-only paths both occur, in both directions and through panic and manual sets. CLK_MHZ=2 and RAMP_US=4 shrink the ramp to 8 cycles. This lets the bench count the exact cycle of each write strobe, and inject a request halfway through a ramp to check that it is dropped.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    REQ_HOLD   = 2'd0,
    REQ_SLOWER = 2'd1,
    REQ_FASTER = 2'd2,
    REQ_PANIC  = 2'd3
  } dvfs_req_e;

  localparam int unsigned EV_DN   = 0;
  localparam int unsigned EV_UP   = 1;
  localparam int unsigned EV_PNC  = 2;
  localparam int unsigned EV_NONE = 3;
  localparam int unsigned EV_NUM  = 4;
endpackage

// File: rtl/dvfs_next_level.sv
module dvfs_next_level
  import dvfs_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 4,
  parameter logic [NUM_LEVELS-1:0] LEVEL_MASK = '1,
  parameter int unsigned LW = 2
) (
  input  logic [LW-1:0] cur,
  input  dvfs_req_e     code,
  output logic [LW-1:0] tgt,
  output logic          move
);
  always_comb begin
    tgt  = cur;
    move = 1'b0;
    unique case (code)
      REQ_SLOWER: begin
        // scan downward so the nearest allowed index above cur wins
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
          if (i > int'(cur) && LEVEL_MASK[i]) begin
            tgt  = LW'(i);
            move = 1'b1;
          end
        end
      end
      REQ_FASTER: begin
        // scan upward so the nearest allowed index below cur wins
        for (int i = 0; i < NUM_LEVELS; i++) begin
          if (i < int'(cur) && LEVEL_MASK[i]) begin
            tgt  = LW'(i);
            move = 1'b1;
          end
        end
      end
      REQ_PANIC: begin
        if (cur != '0) begin
          tgt  = '0;
          move = 1'b1;
        end
      end
      default: begin
        tgt  = cur;
        move = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dvfs_ramp_timer.sv
module dvfs_ramp_timer #(
  parameter int unsigned RAMP_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned TW = (RAMP_CYC < 2) ? 1 : $clog2(RAMP_CYC);

  logic [TW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= TW'(RAMP_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) <= int'(RAMP_CYC) - 1)); // R8
  AST_RAMP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q); // R8
endmodule

// File: rtl/dvfs_event_counters.sv
module dvfs_event_counters
  import dvfs_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [EV_NUM-1:0]             inc,
  output logic [EV_NUM-1:0][CNT_W-1:0]  cnt
);
  for (genvar g = 0; g < EV_NUM; g++) begin : g_ctr
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      c_q <= '0;
      else if (inc[g]) c_q <= c_q + 1'b1;
    end
    assign cnt[g] = c_q;
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc)); // R9
endmodule

// File: rtl/dvfs_lvl_ctrl.sv
module dvfs_lvl_ctrl
  import dvfs_pkg::*;
#(
  parameter int unsigned NUM_LEVELS    = 4,
  parameter logic [NUM_LEVELS-1:0] LEVEL_MASK = 4'b1011,
  parameter int unsigned DEFAULT_LEVEL = 1,
  parameter int unsigned VSW           = 3,
  parameter logic [NUM_LEVELS*VSW-1:0] VSTEP_TABLE = {3'd4, 3'd3, 3'd2, 3'd1},
  parameter logic [NUM_LEVELS-1:0] PLL_SEL_TABLE = 4'b1000,
  parameter int unsigned DIVW          = 8,
  parameter logic [NUM_LEVELS*DIVW-1:0] DIV_TABLE = {8'h13, 8'h12, 8'h11, 8'h10},
  parameter int unsigned PLLW          = 16,
  parameter logic [NUM_LEVELS*PLLW-1:0] PLL_TABLE =
    {16'hA003, 16'hA002, 16'hA001, 16'hA000},
  parameter int unsigned CLK_MHZ       = 100,
  parameter int unsigned RAMP_US       = 100,
  parameter int unsigned CNT_W         = 16,
  localparam int unsigned LW           = (NUM_LEVELS < 2) ? 1 : $clog2(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic             upd_rdy,
  input  logic             req_valid,
  input  logic [1:0]       req_code,
  input  logic             man_valid,
  input  logic [LW-1:0]    man_level,
  output logic [LW-1:0]    level,
  output logic             scale_up,
  output logic [VSW-1:0]   vsteps,
  output logic             pll_sel,
  output logic             ramp_busy,
  output logic             div_wr,
  output logic [DIVW-1:0]  div_val,
  output logic             pll_wr,
  output logic [PLLW-1:0]  pll_val,
  output logic [CNT_W-1:0] cnt_dn,
  output logic [CNT_W-1:0] cnt_up,
  output logic [CNT_W-1:0] cnt_pnc,
  output logic [CNT_W-1:0] cnt_none
);
  localparam int unsigned RAMP_CYC = CLK_MHZ * RAMP_US;

  // table lookups by index, computed instead of part-selecting with a
  // variable that may exceed the table for non power-of-two level counts
  function automatic logic mask_of(input logic [LW-1:0] idx);
    logic r = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) if (int'(idx) == i) r = LEVEL_MASK[i];
    return r;
  endfunction

  function automatic logic psel_of(input logic [LW-1:0] idx);
    logic r = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) if (int'(idx) == i) r = PLL_SEL_TABLE[i];
    return r;
  endfunction

  function automatic logic [VSW-1:0] vstep_of(input logic [LW-1:0] idx);
    logic [VSW-1:0] r = '0;
    for (int i = 0; i < NUM_LEVELS; i++)
      if (int'(idx) == i) r = VSTEP_TABLE[i*VSW +: VSW];
    return r;
  endfunction

  function automatic logic [DIVW-1:0] div_of(input logic [LW-1:0] idx);
    logic [DIVW-1:0] r = '0;
    for (int i = 0; i < NUM_LEVELS; i++)
      if (int'(idx) == i) r = DIV_TABLE[i*DIVW +: DIVW];
    return r;
  endfunction

  function automatic logic [PLLW-1:0] pll_of(input logic [LW-1:0] idx);
    logic [PLLW-1:0] r = '0;
    for (int i = 0; i < NUM_LEVELS; i++)
      if (int'(idx) == i) r = PLL_TABLE[i*PLLW +: PLLW];
    return r;
  endfunction

  localparam logic [LW-1:0] DEF_LVL = LW'(DEFAULT_LEVEL);

  logic [LW-1:0]  level_q;
  logic           scale_up_q;
  logic [VSW-1:0] vsteps_q;
  logic           pll_sel_q;
  logic           pll_upd_q;
  logic           div_wr_q;
  logic           pll_wr_q;

  logic           busy;
  logic           ramp_done;
  dvfs_req_e      code;
  logic [LW-1:0]  auto_tgt;
  logic           auto_move;
  logic           auto_take;
  logic           man_take;
  logic           change;
  logic [LW-1:0]  tgt;
  logic [EV_NUM-1:0] ev_inc;
  logic [EV_NUM-1:0][CNT_W-1:0] ev_cnt;

  assign code = dvfs_req_e'(req_code);

  dvfs_next_level #(
    .NUM_LEVELS (NUM_LEVELS),
    .LEVEL_MASK (LEVEL_MASK),
    .LW         (LW)
  ) u_next (
    .cur  (level_q),
    .code (code),
    .tgt  (auto_tgt),
    .move (auto_move)
  );

  // a request is taken only when nothing masks it
  assign auto_take = auto_en && upd_rdy && req_valid && !busy;
  assign man_take  = !auto_en && upd_rdy && man_valid && !busy &&
                     mask_of(man_level) && (man_level != level_q);
  assign change    = (auto_take && auto_move) || man_take;
  assign tgt       = man_take ? man_level : auto_tgt;

  always_comb begin
    ev_inc          = '0;
    ev_inc[EV_DN]   = auto_take && auto_move && (code == REQ_SLOWER);
    ev_inc[EV_UP]   = auto_take && auto_move && (code == REQ_FASTER);
    ev_inc[EV_PNC]  = auto_take && auto_move && (code == REQ_PANIC);
    ev_inc[EV_NONE] = auto_take && (code == REQ_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q    <= DEF_LVL;
      scale_up_q <= 1'b0;
      vsteps_q   <= VSW'(1);
      pll_sel_q  <= psel_of(DEF_LVL);
      pll_upd_q  <= 1'b0;
    end else if (change) begin
      level_q <= tgt;
      if (tgt < level_q) begin
        scale_up_q <= 1'b1;
        vsteps_q   <= vstep_of(tgt);
      end else begin
        scale_up_q <= 1'b0;
        vsteps_q   <= VSW'(1);
      end
      if (psel_of(tgt) != pll_sel_q) begin
        pll_sel_q <= ~pll_sel_q;
        pll_upd_q <= 1'b1;
      end else begin
        pll_upd_q <= 1'b0;
      end
    end
  end

  dvfs_ramp_timer #(
    .RAMP_CYC (RAMP_CYC)
  ) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .start (change),
    .busy  (busy),
    .done  (ramp_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_wr_q <= 1'b0;
      pll_wr_q <= 1'b0;
    end else begin
      div_wr_q <= ramp_done;
      pll_wr_q <= ramp_done && pll_upd_q;
    end
  end

  dvfs_event_counters #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_inc),
    .cnt   (ev_cnt)
  );

  assign level     = level_q;
  assign scale_up  = scale_up_q;
  assign vsteps    = vsteps_q;
  assign pll_sel   = pll_sel_q;
  assign ramp_busy = busy;
  assign div_wr    = div_wr_q;
  assign pll_wr    = pll_wr_q;
  assign div_val   = div_of(level_q);
  assign pll_val   = pll_of(level_q);
  assign cnt_dn    = ev_cnt[EV_DN];
  assign cnt_up    = ev_cnt[EV_UP];
  assign cnt_pnc   = ev_cnt[EV_PNC];
  assign cnt_none  = ev_cnt[EV_NONE];

  AST_LEVEL_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    mask_of(level_q)); // R2
  AST_HOLD_DURING_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(level_q)); // R5
  AST_DIR_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> (scale_up_q == (level_q < $past(level_q)))); // R6
  AST_PLL_WITH_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    pll_wr_q |-> div_wr_q); // R7
  AST_WRITE_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr_q |-> $fell(busy)); // R8
  AST_PANIC_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cnt[EV_PNC] != $past(ev_cnt[EV_PNC])) |-> (level_q == '0)); // R4
  AST_NO_AUTO_MOVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !man_valid) |=> $stable(level_q)); // R5
endmodule

// File: tb/test_dvfs_lvl_ctrl.sv
module test_dvfs_lvl_ctrl;
  localparam int unsigned NL   = 6;
  localparam logic [NL-1:0] MASK = 6'b110101;
  localparam int unsigned DEFL = 2;
  localparam int unsigned VSW  = 3;
  localparam logic [NL*VSW-1:0] VST = {3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1};
  localparam logic [NL-1:0] PSEL = 6'b110000;
  localparam int unsigned DIVW = 8;
  localparam logic [NL*DIVW-1:0] DIVT = {8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
  localparam int unsigned PLLW = 16;
  localparam logic [NL*PLLW-1:0] PLLT =
    {16'hA005, 16'hA004, 16'hA003, 16'hA002, 16'hA001, 16'hA000};
  localparam int unsigned RAMP = 8;
  localparam int unsigned LW   = 3;
  localparam int unsigned CW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, upd_rdy = 1'b0, req_valid = 1'b0, man_valid = 1'b0;
  logic [1:0] req_code = 2'd0;
  logic [LW-1:0] man_level = '0;
  logic [LW-1:0] level;
  logic scale_up, pll_sel, ramp_busy, div_wr, pll_wr;
  logic [VSW-1:0] vsteps;
  logic [DIVW-1:0] div_val;
  logic [PLLW-1:0] pll_val;
  logic [CW-1:0] cnt_dn, cnt_up, cnt_pnc, cnt_none;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;
  logic [DIVW+PLLW:0] expq[$];

  always #5 clk = ~clk;

  dvfs_lvl_ctrl #(
    .NUM_LEVELS(NL), .LEVEL_MASK(MASK), .DEFAULT_LEVEL(DEFL), .VSW(VSW),
    .VSTEP_TABLE(VST), .PLL_SEL_TABLE(PSEL), .DIVW(DIVW), .DIV_TABLE(DIVT),
    .PLLW(PLLW), .PLL_TABLE(PLLT), .CLK_MHZ(2), .RAMP_US(4), .CNT_W(CW)
  ) i_dvfs_lvl_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .upd_rdy(upd_rdy),
    .req_valid(req_valid), .req_code(req_code), .man_valid(man_valid),
    .man_level(man_level), .level(level), .scale_up(scale_up),
    .vsteps(vsteps), .pll_sel(pll_sel), .ramp_busy(ramp_busy),
    .div_wr(div_wr), .div_val(div_val), .pll_wr(pll_wr), .pll_val(pll_val),
    .cnt_dn(cnt_dn), .cnt_up(cnt_up), .cnt_pnc(cnt_pnc), .cnt_none(cnt_none)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: every divider write is compared with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && div_wr) begin
      if (expq.size() == 0) chk("R8 unexpected write", 1, 0);
      else begin
        logic [DIVW+PLLW:0] e;
        e = expq.pop_front();
        chk("R8 div_val", div_val, e[DIVW+PLLW:PLLW+1]);
        chk("R7 pll_wr", pll_wr, e[PLLW]);
        if (e[PLLW]) chk("R8 pll_val", pll_val, e[PLLW-1:0]);
      end
    end
  end

  task automatic pulse(input bit man, input logic [1:0] code, input logic [LW-1:0] lv);
    @(negedge clk);
    if (man) begin man_valid = 1; man_level = lv; end
    else     begin req_valid = 1; req_code = code; end
    @(negedge clk);
    man_valid = 0;
    req_valid = 0;
  endtask

  // expected change: level, direction, steps, then timed write
  task automatic move(input string tag, input bit man, input logic [1:0] code,
                      input logic [LW-1:0] lv, input int exp_lvl,
                      input bit exp_up, input int exp_vs, input bit exp_pllw,
                      input bit poke);
    expq.push_back({DIVT[exp_lvl*DIVW +: DIVW], exp_pllw, PLLT[exp_lvl*PLLW +: PLLW]});
    pulse(man, code, lv);
    chk({tag, " level"}, level, exp_lvl);
    chk("R6 scale_up", scale_up, exp_up);
    chk("R6 vsteps", vsteps, exp_vs);
    chk("R7 pll_sel", pll_sel, PSEL[exp_lvl]);
    chk("R8 busy set", ramp_busy, 1);
    if (poke) begin req_valid = 1; req_code = 2'd3; end
    for (int k = 1; k < RAMP; k++) begin
      @(negedge clk);
      req_valid = 0;
    end
    chk("R5 level held in ramp", level, exp_lvl);
    chk("R8 busy at end of ramp", ramp_busy, 1);
    chk("R8 no early write", div_wr, 0);
    @(negedge clk);
    chk("R8 write strobe", div_wr, 1);
    chk("R8 busy cleared", ramp_busy, 0);
    @(negedge clk);
    chk("R8 one-cycle strobe", div_wr, 0);
  endtask

  task automatic ignored(input string tag, input bit man, input logic [1:0] code,
                         input logic [LW-1:0] lv);
    logic [LW-1:0] l0;
    l0 = level;
    pulse(man, code, lv);
    chk({tag, " level"}, level, l0);
    chk({tag, " busy"}, ramp_busy, 0);
    @(negedge clk);
    chk({tag, " no write"}, div_wr, 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 level", level, DEFL);
    chk("R1 pll_sel", pll_sel, PSEL[DEFL]);
    chk("R1 busy", ramp_busy, 0);
    chk("R1 strobes", {div_wr, pll_wr}, 0);
    chk("R1 counters", cnt_dn | cnt_up | cnt_pnc | cnt_none, 0);

    upd_rdy = 1;
    ignored("R5 auto off", 0, 2'd1, '0);
    auto_en = 1;
    // R2: 2 -> 4 skips disabled 3, PLL swap; panic inside ramp is dropped (R5)
    move("R2", 0, 2'd1, '0, 4, 0, 1, 1, 1);
    chk("R5 panic in ramp not counted", cnt_pnc, 0);
    move("R2 divider only", 0, 2'd1, '0, 5, 0, 1, 0, 0);
    ignored("R2 at last index", 0, 2'd1, '0);
    chk("R9 dn count", cnt_dn, 2);
    move("R3", 0, 2'd2, '0, 4, 1, 5, 0, 0);
    move("R4", 0, 2'd3, '0, 0, 1, 1, 1, 0);
    ignored("R3 at zero", 0, 2'd2, '0);
    ignored("R4 at zero", 0, 2'd3, '0);
    pulse(0, 2'd0, '0);
    chk("R9 hold count", cnt_none, 1);
    upd_rdy = 0;
    ignored("R5 not ready", 0, 2'd1, '0);
    upd_rdy = 1;
    move("R2 skip 1", 0, 2'd1, '0, 2, 0, 1, 0, 0);
    ignored("R10 manual with auto on", 1, 2'd0, 3'd0);
    auto_en = 0;
    ignored("R5 auto off again", 0, 2'd2, '0);
    ignored("R10 disabled level", 1, 2'd0, 3'd3);
    ignored("R10 same level", 1, 2'd0, 3'd2);
    move("R10", 1, 2'd0, 3'd5, 5, 0, 1, 1, 0);
    chk("R9 dn final", cnt_dn, 3);
    chk("R9 up final", cnt_up, 1);
    chk("R9 pnc final", cnt_pnc, 1);
    chk("R9 none final", cnt_none, 1);
    chk("R8 all writes seen", expq.size(), 0);
    finish_run();
  end
endmodule